// File: doc/BRIEF.md
# Region Based Memory Protection Checker

This block decides whether a single bus access may proceed. Eight protection windows, each with a power-of-two size, a size-aligned base, an enable, a three-bit access-permission code and an execute-never bit, are compared against the access address in the same cycle. When several windows cover the address, the window with the largest index sets the rules. An address covered by no enabled window falls into a background window that only privileged accesses may use. Instruction fetches and data accesses use the same window settings.

The check itself is purely combinational, so the allow result, the hit flag and the index of the deciding window are valid in the cycle the access is presented. A denied access that is marked valid raises a one-cycle fault strobe on the following clock. The windows and a global protection enable are loaded through a plain synchronous write port. While protection is off, every access is allowed.

Top module: `region_guard`

## Requirements
- R1: An enabled window i covers an address when the address bits above the window size equal those of its base. `chk_hit` is then 1 and `chk_region` is i, in the same cycle as the access.
- R2: When several enabled windows cover the address, `chk_region` is the largest covering index, and that window's settings decide `chk_allow`.
- R3: With protection on and no window covering the address, `chk_hit` is 0 and `chk_region` is 0. `chk_allow` equals `acc_priv` for reads, writes and fetches alike.
- R4: Permission codes (`cfg_attr[8:6]`): 0 denies all; 1 allows privileged read/write only; 2 allows privileged read/write and user read; 3 allows everything; 4 denies all; 5 allows privileged read only; 6 and 7 allow reads from any level and deny all writes.
- R5: A fetch (`acc_fetch`=1) is judged as a read and `acc_write` is ignored. A fetch that hits a window with its execute-never bit (`cfg_attr[9]`) set is denied.
- R6: `chk_fault` is 1 in the cycle after an access with `acc_valid`=1 and `chk_allow`=0, and is 0 in every other cycle. An access with `acc_valid`=0 never raises a fault.
- R7: While the global enable is 0, `chk_allow` is 1, `chk_hit` is 0 and `chk_region` is 0 for every access. The global enable is written from `ctl_en` when `ctl_we` is 1.
- R8: The size code (`cfg_attr[5:1]`) c gives a window of 2^(c+1) bytes. Codes below 4 act as 4 (32 bytes), code 31 covers all 4 GB, and base bits below the size are ignored.
- R9: The reset state, and the value after any reset cycle, has all windows disabled, protection disabled and `chk_fault` 0. A write with `cfg_we`=1 loads window `cfg_region` from `cfg_base` and `cfg_attr` at the clock edge.
- R10: A window with enable bit `cfg_attr[0]`=0 never covers any address, whatever its base, size and permissions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Window write strobe |
| cfg_region | input | 3 | Index of the window being written |
| cfg_base | input | 32 | Base address for the written window |
| cfg_attr | input | 10 | {xn, perm[2:0], size code[4:0], enable} |
| ctl_we | input | 1 | Global enable write strobe |
| ctl_en | input | 1 | Global enable value |
| acc_valid | input | 1 | Access qualifier for the fault strobe |
| acc_addr | input | 32 | Access address |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| acc_fetch | input | 1 | 1 for an instruction fetch |
| acc_priv | input | 1 | 1 for privileged level |
| chk_allow | output | 1 | Access permitted |
| chk_hit | output | 1 | An enabled window covers the address |
| chk_region | output | 3 | Index of the deciding window |
| chk_fault | output | 1 | Registered denial strobe |

## Verification
The bench places windows so they overlap partly and fully, including a whole-space window at index 7. A priority encoder that picked the lowest index, or stopped at the first hit, would report the wrong region and apply the wrong permissions there. It sweeps all eight permission codes against every mix of privilege and direction, where a mistake in the decode table shows up as a wrong allow result. It also programs a base that is not aligned and a size code below the minimum. A design that did not clamp the code or mask the base would miss addresses inside the 32-byte window. It also drives denied accesses with the valid bit low and with protection off, where a fault strobe not gated by the valid bit, or a check that forgot the global enable, would raise spurious faults.

// File: rtl/region_guard_pkg.sv
package region_guard_pkg;

  typedef enum logic [2:0] {
    PERM_NONE      = 3'd0,
    PERM_PRIV_RW   = 3'd1,
    PERM_PRIV_RW_U = 3'd2,
    PERM_FULL      = 3'd3,
    PERM_RSVD      = 3'd4,
    PERM_PRIV_RO   = 3'd5,
    PERM_RO        = 3'd6,
    PERM_RO_ALT    = 3'd7
  } perm_e;

  // Returns 1 when the permission code lets this access through.
  function automatic logic perm_grants(input logic [2:0] code, input logic priv,
                                       input logic is_wr);
    logic ok;
    case (perm_e'(code))
      PERM_NONE:      ok = 1'b0;
      PERM_PRIV_RW:   ok = priv;
      PERM_PRIV_RW_U: ok = priv | ~is_wr;
      PERM_FULL:      ok = 1'b1;
      PERM_RSVD:      ok = 1'b0;
      PERM_PRIV_RO:   ok = priv & ~is_wr;
      default:        ok = ~is_wr;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/region_guard_regs.sv
module region_guard_regs #(
  parameter int N      = 8,
  parameter int ADDR_W = 32,
  parameter int CODE_W = 5,
  parameter int IDX_W  = 3,
  parameter int ATTR_W = CODE_W + 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_region,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [ATTR_W-1:0] cfg_attr,
  input  logic              ctl_we,
  input  logic              ctl_en,
  output logic              glb_en,
  output logic              r_en   [N],
  output logic [ADDR_W-1:0] r_base [N],
  output logic [CODE_W-1:0] r_code [N],
  output logic [2:0]        r_perm [N],
  output logic              r_xn   [N]
);
  localparam int CODE_LSB = 1;
  localparam int PERM_LSB = CODE_LSB + CODE_W;
  localparam int XN_BIT   = PERM_LSB + 3;

  always_ff @(posedge clk) begin
    if (rst)         glb_en <= 1'b0;
    else if (ctl_we) glb_en <= ctl_en;
  end

  for (genvar gi = 0; gi < N; gi++) begin : g_win
    logic sel;
    assign sel = cfg_we && (cfg_region == IDX_W'(gi));

    always_ff @(posedge clk) begin
      if (rst) begin
        r_en[gi]   <= 1'b0;
        r_base[gi] <= '0;
        r_code[gi] <= '0;
        r_perm[gi] <= '0;
        r_xn[gi]   <= 1'b0;
      end else if (sel) begin
        r_en[gi]   <= cfg_attr[0];
        r_base[gi] <= cfg_base;
        r_code[gi] <= cfg_attr[CODE_LSB +: CODE_W];
        r_perm[gi] <= cfg_attr[PERM_LSB +: 3];
        r_xn[gi]   <= cfg_attr[XN_BIT];
      end
    end

    // R9
    write_lands_chk: assert property (@(posedge clk) disable iff (rst)
      (cfg_we && cfg_region == IDX_W'(gi)) |=>
        (r_en[gi] == $past(cfg_attr[0]) && r_base[gi] == $past(cfg_base)));
  end

endmodule

// File: rtl/region_guard_match.sv
module region_guard_match #(
  parameter int ADDR_W   = 32,
  parameter int CODE_W   = 5,
  parameter int MIN_CODE = 4
) (
  input  logic              en,
  input  logic [ADDR_W-1:0] base,
  input  logic [CODE_W-1:0] code,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  logic [CODE_W-1:0] eff_code;
  logic [ADDR_W-1:0] keep;

  assign eff_code = (code < CODE_W'(MIN_CODE)) ? CODE_W'(MIN_CODE) : code;

  // Bit b takes part in the compare only when it lies above the window size.
  for (genvar b = 0; b < ADDR_W; b++) begin : g_bit
    assign keep[b] = (32'(eff_code) < 32'(b));
  end

  assign hit = en && (((addr ^ base) & keep) == '0);

endmodule

// File: rtl/region_guard_pick.sv
module region_guard_pick #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     hits,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (hits[i]) idx = IDX_W'(i);
    end
  end

  assign any = |hits;

endmodule

// File: rtl/region_guard.sv
module region_guard
  import region_guard_pkg::*;
#(
  parameter int N        = 8,
  parameter int ADDR_W   = 32,
  parameter int MIN_CODE = 4,
  localparam int IDX_W   = $clog2(N),
  localparam int CODE_W  = $clog2(ADDR_W),
  localparam int ATTR_W  = CODE_W + 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_region,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [ATTR_W-1:0] cfg_attr,
  input  logic              ctl_we,
  input  logic              ctl_en,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_write,
  input  logic              acc_fetch,
  input  logic              acc_priv,
  output logic              chk_allow,
  output logic              chk_hit,
  output logic [IDX_W-1:0]  chk_region,
  output logic              chk_fault
);
  logic              glb_en;
  logic              r_en   [N];
  logic [ADDR_W-1:0] r_base [N];
  logic [CODE_W-1:0] r_code [N];
  logic [2:0]        r_perm [N];
  logic              r_xn   [N];
  logic [N-1:0]      hit_vec;
  logic              any_hit;
  logic [IDX_W-1:0]  win_idx;
  logic              is_wr;
  logic              win_ok;
  logic              fault_q;

  region_guard_regs #(
    .N(N), .ADDR_W(ADDR_W), .CODE_W(CODE_W), .IDX_W(IDX_W), .ATTR_W(ATTR_W)
  ) u_regs (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_region(cfg_region), .cfg_base(cfg_base), .cfg_attr(cfg_attr),
    .ctl_we(ctl_we), .ctl_en(ctl_en),
    .glb_en(glb_en), .r_en(r_en), .r_base(r_base), .r_code(r_code),
    .r_perm(r_perm), .r_xn(r_xn)
  );

  for (genvar gi = 0; gi < N; gi++) begin : g_match
    region_guard_match #(
      .ADDR_W(ADDR_W), .CODE_W(CODE_W), .MIN_CODE(MIN_CODE)
    ) u_match (
      .en(r_en[gi]), .base(r_base[gi]), .code(r_code[gi]),
      .addr(acc_addr), .hit(hit_vec[gi])
    );
  end

  region_guard_pick #(.N(N), .IDX_W(IDX_W)) u_pick (
    .hits(hit_vec), .any(any_hit), .idx(win_idx)
  );

  // A fetch is a read for permission purposes.
  assign is_wr  = acc_write & ~acc_fetch;
  assign win_ok = perm_grants(r_perm[win_idx], acc_priv, is_wr)
                  & ~(acc_fetch & r_xn[win_idx]);

  always_comb begin
    if (!glb_en)      chk_allow = 1'b1;
    else if (any_hit) chk_allow = win_ok;
    else              chk_allow = acc_priv;
  end

  assign chk_hit    = glb_en & any_hit;
  assign chk_region = chk_hit ? win_idx : '0;

  always_ff @(posedge clk) begin
    if (rst) fault_q <= 1'b0;
    else     fault_q <= acc_valid & ~chk_allow;
  end
  assign chk_fault = fault_q;

  // R1, R2
  top_wins_chk: assert property (@(posedge clk) disable iff (rst)
    chk_hit |-> ((hit_vec >> chk_region) == N'(1)));

  // R3
  bg_user_chk: assert property (@(posedge clk) disable iff (rst)
    (glb_en && !chk_hit && !acc_priv) |-> !chk_allow);

  // R5
  xn_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    (chk_hit && acc_fetch && r_xn[chk_region]) |-> !chk_allow);

  // R6
  fault_raise_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !chk_allow) |=> chk_fault);

  // R6
  fault_cause_chk: assert property (@(posedge clk) disable iff (rst)
    chk_fault |-> $past(acc_valid && !chk_allow));

  // R7
  off_open_chk: assert property (@(posedge clk) disable iff (rst)
    !glb_en |-> (chk_allow && !chk_hit && chk_region == '0));

endmodule

// File: tb/region_guard_tb.sv
`timescale 1ns/1ps
module region_guard_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we;
  logic [2:0]  cfg_region;
  logic [31:0] cfg_base;
  logic [9:0]  cfg_attr;
  logic        ctl_we, ctl_en;
  logic        acc_valid, acc_write, acc_fetch, acc_priv;
  logic [31:0] acc_addr;
  logic        chk_allow, chk_hit, chk_fault;
  logic [2:0]  chk_region;

  always #2.5 clk = ~clk;

  region_guard u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_region(cfg_region),
    .cfg_base(cfg_base), .cfg_attr(cfg_attr), .ctl_we(ctl_we), .ctl_en(ctl_en),
    .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_write(acc_write),
    .acc_fetch(acc_fetch), .acc_priv(acc_priv), .chk_allow(chk_allow),
    .chk_hit(chk_hit), .chk_region(chk_region), .chk_fault(chk_fault)
  );

  // Behavioural reference state
  bit          m_en   [8];
  longint      m_base [8];
  int          m_code [8];
  int          m_perm [8];
  bit          m_xn   [8];
  bit          m_glb;
  bit          m_fault;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 0;

  function automatic bit m_perm_ok(int p, bit priv, bit wr);
    case (p)
      0, 4:    return 0;
      1:       return priv;
      2:       return priv || !wr;
      3:       return 1;
      5:       return priv && !wr;
      default: return !wr;
    endcase
  endfunction

  task automatic expect_bit(string tag, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s addr=%h actual=%b expected=%b", tag, what, acc_addr, act, exp);
    end
  endtask

  // One cycle: compare at negedge+1, then let the posedge apply inputs.
  task automatic cyc(string tag);
    bit     e_hit, e_allow, wr;
    int     e_idx, c;
    longint sz, lo;
    #1;
    e_hit = 0; e_idx = 0;
    if (m_glb) begin
      for (int i = 7; i >= 0; i--) begin
        if (!e_hit && m_en[i]) begin
          c  = (m_code[i] < 4) ? 4 : m_code[i];
          sz = longint'(1) << (c + 1);
          lo = m_base[i] - (m_base[i] % sz);
          if (longint'(acc_addr) >= lo && longint'(acc_addr) < lo + sz) begin
            e_hit = 1; e_idx = i;
          end
        end
      end
    end
    wr = acc_write && !acc_fetch;
    if (!m_glb)      e_allow = 1;
    else if (!e_hit) e_allow = acc_priv;
    else             e_allow = m_perm_ok(m_perm[e_idx], acc_priv, wr) && !(acc_fetch && m_xn[e_idx]);
    if (!rst) begin
      expect_bit(tag, "allow", chk_allow, e_allow);
      expect_bit(tag, "hit", chk_hit, e_hit);
      n_chk++;
      if (chk_region !== 3'(e_idx)) begin
        n_fail++;
        $display("FAIL %s region addr=%h actual=%0d expected=%0d", tag, acc_addr, chk_region, e_idx);
      end
    end
    expect_bit(tag, "fault", chk_fault, m_fault);
    // state update for the coming edge
    if (rst) begin
      m_glb = 0; m_fault = 0;
      for (int i = 0; i < 8; i++) begin
        m_en[i] = 0; m_base[i] = 0; m_code[i] = 0; m_perm[i] = 0; m_xn[i] = 0;
      end
    end else begin
      m_fault = acc_valid && !e_allow;
      if (ctl_we) m_glb = ctl_en;
      if (cfg_we) begin
        m_en[cfg_region]   = cfg_attr[0];
        m_base[cfg_region] = longint'(cfg_base);
        m_code[cfg_region] = int'(cfg_attr[5:1]);
        m_perm[cfg_region] = int'(cfg_attr[8:6]);
        m_xn[cfg_region]   = cfg_attr[9];
      end
    end
    @(negedge clk);
  endtask

  task automatic acc(string tag, logic [31:0] a, bit v, bit w, bit f, bit p);
    acc_addr = a; acc_valid = v; acc_write = w; acc_fetch = f; acc_priv = p;
    cyc(tag);
  endtask

  task automatic set_win(int idx, logic [31:0] base, bit en, int code, int perm, bit xn);
    cfg_we = 1; cfg_region = 3'(idx); cfg_base = base;
    cfg_attr = {xn, 3'(perm), 5'(code), en};
    acc_valid = 0;
    cyc("R9");
    cfg_we = 0;
  endtask

  task automatic set_glb(bit en);
    ctl_we = 1; ctl_en = en; acc_valid = 0;
    cyc("R7");
    ctl_we = 0;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] hot [6];
    rst = 1; cfg_we = 0; cfg_region = 0; cfg_base = 0; cfg_attr = 0;
    ctl_we = 0; ctl_en = 0;
    acc_valid = 0; acc_addr = 0; acc_write = 0; acc_fetch = 0; acc_priv = 0;
    @(negedge clk);
    cyc("R9");
    acc("R9", 32'h1234_5678, 1, 1, 0, 0);
    rst = 0;
    acc("R9", 32'h1234_5678, 1, 1, 0, 0);

    // protection off: everything passes
    for (int i = 0; i < 20; i++)
      acc("R7", $urandom, 1, 1'($urandom), 1'($urandom), 1'($urandom));

    set_glb(1);
    // background window
    acc("R3", 32'h4000_0000, 1, 0, 0, 1);
    acc("R3", 32'h4000_0000, 1, 0, 0, 0);
    acc("R6", 32'h4000_0004, 1, 1, 0, 0);
    acc("R6", 32'h4000_0008, 0, 1, 0, 0);
    acc("R6", 32'h4000_0008, 0, 0, 0, 1);
    acc("R3", 32'h4000_000C, 1, 0, 1, 1);

    // layered windows
    set_win(1, 32'h2000_0000, 1, 11, 1, 0);   // 4 KB, privileged RW
    set_win(3, 32'h2000_0000, 1,  9, 3, 0);   // 1 KB, full
    set_win(5, 32'h2000_0800, 1,  7, 6, 1);   // 256 B, read only, no exec
    set_win(0, 32'h0000_1234, 1,  2, 2, 0);   // code below minimum, unaligned
    set_win(7, 32'h0000_0000, 0, 31, 0, 0);   // disabled whole space

    acc("R1", 32'h2000_0C00, 1, 1, 0, 1);
    acc("R1", 32'h2000_0C00, 1, 1, 0, 0);
    acc("R2", 32'h2000_0100, 1, 1, 0, 0);
    acc("R2", 32'h2000_0810, 1, 0, 0, 0);
    acc("R5", 32'h2000_0810, 1, 0, 1, 1);
    acc("R5", 32'h2000_0C10, 1, 1, 1, 1);
    acc("R8", 32'h0000_1220, 1, 0, 0, 0);
    acc("R8", 32'h0000_123F, 1, 1, 0, 1);
    acc("R8", 32'h0000_1240, 1, 0, 0, 0);
    acc("R10", 32'h8000_0000, 1, 0, 0, 0);
    acc("R1", 32'h2000_1000, 1, 0, 0, 0);

    // permission sweep on window 6
    for (int p = 0; p < 8; p++) begin
      set_win(6, 32'h6000_0000, 1, 15, p, 0);
      for (int k = 0; k < 4; k++)
        acc("R4", 32'h6000_0040 + 32'(k), 1, 1'(k[0]), 0, 1'(k[1]));
      acc("R5", 32'h6000_0080, 1, 1, 1, 0);
    end

    // random traffic over the layered map
    hot[0] = 32'h2000_0000; hot[1] = 32'h2000_0800; hot[2] = 32'h0000_1200;
    hot[3] = 32'h6000_0000; hot[4] = 32'h4000_0000; hot[5] = 32'h2000_0F00;
    for (int i = 0; i < 3000; i++)
      acc("R1/R2/R4/R5/R8", hot[$urandom_range(0, 5)] + 32'($urandom_range(0, 255)),
          1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));

    // whole-space window on top denies all
    set_win(7, 32'h0000_0000, 1, 31, 0, 0);
    for (int i = 0; i < 50; i++)
      acc("R2", $urandom, 1, 1'($urandom), 1'($urandom), 1'($urandom));
    set_win(7, 32'hFFFF_FFFF, 1, 0, 3, 0);
    acc("R8", 32'hFFFF_FFE0, 1, 1, 0, 0);
    acc("R8", 32'hFFFF_FFDF, 1, 1, 0, 0);

    set_glb(0);
    for (int i = 0; i < 30; i++)
      acc("R7", $urandom, 1, 1'($urandom), 1'($urandom), 1'($urandom));

    // reset clears all windows
    rst = 1;
    cyc("R9");
    rst = 0;
    acc("R9", 32'h2000_0000, 1, 1, 0, 0);
    set_glb(1);
    acc("R9", 32'h2000_0000, 1, 1, 0, 0);
    acc("R6", 32'h2000_0000, 0, 0, 0, 1);
    cyc("R6");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule